// File: doc/BRIEF.md
# Multi-Lane Transmit Feeder with Pre-Fill

This block stands between a user word source and one transmit FIFO per lane of a multi-lane serial link. Each stored lane word is 66 bits: a 64-bit payload in bits 63:0, a control flag in bit 64 and a valid flag in bit 65. The feeder holds all lanes idle until the link side reports that it is out of reset. On a multi-lane link it then fills every lane FIFO with a fixed filler word until the lane-alignment indication goes high. After that it forwards user beats. A beat carries one payload and one control flag for each lane and is written to all lanes together.

The user side is a valid/ready stream. A beat moves on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` depends combinationally on the link and FIFO state and never on `s_valid`. The source may hold or withdraw a beat freely while `s_ready` is low. Each lane FIFO reports readiness while its fill level is below a partial-empty threshold. The feeder ORs these readiness signals and offers user data only while the combined readiness is high. The FIFOs are drained on the link side through per-lane pop strobes. The head word is shown combinationally.

Top module: `mlane_tx_feeder`

## Requirements
- R1: On a clock edge with `rst` high, every lane FIFO becomes empty (`m_avail` all 0), the feeder returns to the hold phase and `s_ready` is low once reset is released with `link_ready` low.
- R2: While `link_ready` is low, no word of any kind is written into any lane FIFO and `s_ready` is low.
- R3: On a multi-lane link, in the hold phase, every cycle with `link_ready` high writes the filler word into every lane FIFO that is not full, starting with the very cycle `link_ready` rises. The filler word is bit 65 = 1, bit 64 = 1, payload 64'hF1E1_D00D_5EED_0FF1. `s_ready` stays low throughout.
- R4: On a multi-lane link, the cycle in which `align_done` is high with `link_ready` high still writes filler. User beats can be accepted from the next cycle on, and no earlier.
- R5: With a single lane there is no filler phase: `s_ready` can be high in the same cycle that `link_ready` first goes high.
- R6: `lane_ready[i]` is high exactly when lane i holds fewer than THRESH words (default THRESH = 8, DEPTH = 16).
- R7: In the user phase, `s_ready` = `link_ready` AND (OR of `lane_ready`) AND no lane full. An accepted beat writes {1, `s_ctl[i]`, `s_data[64*i +: 64]`} into lane i.
- R8: User payloads leave each lane in the order they were accepted, with none lost or duplicated.
- R9: `m_avail[i]` is high while lane i is non-empty. `m_word[66*i +: 66]` shows its oldest word, and a high `m_pop[i]` removes that word at the clock edge.
- R10: A lane that holds DEPTH words accepts no further write. A filler word offered to it is dropped, so the lane never holds more than DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_ready | input | 1 | Link side out of reset; lanes may be written |
| align_done | input | 1 | Lane alignment complete |
| s_valid | input | 1 | User beat valid |
| s_ready | output | 1 | User beat accepted this cycle when valid |
| s_data | input | 64*LANES | Per-lane payloads, lane i in bits 64*i +: 64 |
| s_ctl | input | LANES | Per-lane control flags |
| lane_ready | output | LANES | Per-lane fill below threshold |
| m_pop | input | LANES | Per-lane read strobe |
| m_word | output | 66*LANES | Per-lane head word, lane i in bits 66*i +: 66 |
| m_avail | output | LANES | Per-lane non-empty |

## Verification
`s_ready` and `lane_ready` are combinational from the current fill levels, the phase register and `link_ready`, so the bench checks them in the same cycle that it drives inputs. It drives on the falling edge and samples shortly after. A write or pop takes effect at the next rising edge, so fill levels, `m_avail` and head words are checked at the following falling edge. The phase moves to user data at the edge where alignment is seen, so `s_ready` is expected high from the cycle after that edge. The bench keeps a per-lane queue of accepted words and compares each popped head word against it at the moment of the pop.

// File: rtl/mtf_pkg.sv
package mtf_pkg;
  localparam int PAY_W  = 64;
  localparam int WORD_W = PAY_W + 2;
  localparam int CTL_BIT = PAY_W;
  localparam int VLD_BIT = PAY_W + 1;
  localparam logic [PAY_W-1:0] FILL_PAY = 64'hF1E1_D00D_5EED_0FF1;

  typedef enum logic {PH_HOLD, PH_LIVE} phase_t;

  function automatic logic [WORD_W-1:0] make_word(input logic ctl, input logic [PAY_W-1:0] pay);
    return {1'b1, ctl, pay};
  endfunction
endpackage

// File: rtl/mtf_lane_fifo.sv
module mtf_lane_fifo
  import mtf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int THRESH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_word,
  output logic              avail,
  output logic              full,
  output logic              rdy
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic do_wr, do_rd;

  assign full  = (cnt == CW'(DEPTH));
  assign avail = (cnt != '0);
  assign rdy   = (cnt < CW'(THRESH));
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && avail;
  assign rd_word = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/mtf_phase_ctrl.sv
module mtf_phase_ctrl
  import mtf_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic link_ready,
  input  logic align_done,
  output logic fill_now,
  output logic user_ok,
  output logic live
);
  localparam bit MULTI = (LANES > 1);

  phase_t ph;

  always_ff @(posedge clk) begin
    if (rst) ph <= PH_HOLD;
    else if (ph == PH_HOLD && link_ready && (align_done || !MULTI)) ph <= PH_LIVE;
  end

  assign live     = (ph == PH_LIVE);
  assign fill_now = MULTI && (ph == PH_HOLD) && link_ready;
  assign user_ok  = link_ready && ((ph == PH_LIVE) || !MULTI);
endmodule

// File: rtl/mlane_tx_feeder.sv
module mlane_tx_feeder
  import mtf_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int DEPTH  = 16,
  parameter int THRESH = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      link_ready,
  input  logic                      align_done,
  input  logic                      s_valid,
  output logic                      s_ready,
  input  logic [LANES*PAY_W-1:0]    s_data,
  input  logic [LANES-1:0]          s_ctl,
  output logic [LANES-1:0]          lane_ready,
  input  logic [LANES-1:0]          m_pop,
  output logic [LANES*WORD_W-1:0]   m_word,
  output logic [LANES-1:0]          m_avail
);
  logic fill_now, user_ok, live;
  logic [LANES-1:0] lane_full;
  logic take;

  mtf_phase_ctrl #(.LANES(LANES)) ctrl_i (
    .clk(clk), .rst(rst), .link_ready(link_ready), .align_done(align_done),
    .fill_now(fill_now), .user_ok(user_ok), .live(live)
  );

  assign s_ready = user_ok && (|lane_ready) && !(|lane_full);
  assign take    = s_valid && s_ready;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [WORD_W-1:0] wword;
    logic              wen;
    assign wword = fill_now ? make_word(1'b1, FILL_PAY)
                            : make_word(s_ctl[i], s_data[i*PAY_W +: PAY_W]);
    assign wen   = fill_now || take;

    mtf_lane_fifo #(.DEPTH(DEPTH), .THRESH(THRESH)) fifo_i (
      .clk(clk), .rst(rst),
      .wr_en(wen), .wr_word(wword),
      .rd_en(m_pop[i]), .rd_word(m_word[i*WORD_W +: WORD_W]),
      .avail(m_avail[i]), .full(lane_full[i]), .rdy(lane_ready[i])
    );
  end
endmodule

// File: rtl/mtf_checker.sv
module mtf_checker #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             link_ready,
  input logic             align_done,
  input logic             s_ready,
  input logic [LANES-1:0] lane_ready,
  input logic [LANES-1:0] m_avail,
  input logic             live
);
  localparam bit MULTI = (LANES > 1);

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (m_avail == '0 && !live));

  p_quiet_unlinked_r2: assert property (@(posedge clk) disable iff (rst)
    (!link_ready && m_avail == '0) |=> (m_avail == '0));

  p_hold_blocks_user_r4: assert property (@(posedge clk) disable iff (rst)
    (MULTI && !live) |-> !s_ready);

  p_live_after_align_r4: assert property (@(posedge clk) disable iff (rst)
    (MULTI && $rose(live)) |-> $past(align_done && link_ready));

  p_empty_is_ready_r6: assert property (@(posedge clk) disable iff (rst)
    ((~m_avail) & (~lane_ready)) == '0);

  p_ready_needs_room_r7: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> (link_ready && (|lane_ready)));
endmodule

bind mlane_tx_feeder mtf_checker #(.LANES(LANES)) chk_i (
  .clk(clk), .rst(rst), .link_ready(link_ready), .align_done(align_done),
  .s_ready(s_ready), .lane_ready(lane_ready), .m_avail(m_avail), .live(live)
);

// File: tb/mlane_tx_feeder_tb_top.sv
module mlane_tx_feeder_tb_top;
  localparam logic [65:0] FILLW = {1'b1, 1'b1, 64'hF1E1_D00D_5EED_0FF1};
  localparam int NBEAT = 60;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic link_ready = 0, align_done = 0, s_valid = 0;
  logic s_ready;
  logic [127:0] s_data = '0;
  logic [1:0] s_ctl = '0, lane_ready, m_pop = '0, m_avail;
  logic [131:0] m_word;

  logic u_link = 0, u_align = 0, u_valid = 0, u_ready;
  logic [63:0] u_data = '0;
  logic u_ctl = 0, u_lrdy, u_pop = 0, u_avail;
  logic [65:0] u_word;

  int total = 0, bad = 0;
  bit finished = 0;

  mlane_tx_feeder #(.LANES(2), .DEPTH(16), .THRESH(8)) dut_i (
    .clk(clk), .rst(rst), .link_ready(link_ready), .align_done(align_done),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_ctl(s_ctl),
    .lane_ready(lane_ready), .m_pop(m_pop), .m_word(m_word), .m_avail(m_avail));

  mlane_tx_feeder #(.LANES(1), .DEPTH(4), .THRESH(2)) dut1_i (
    .clk(clk), .rst(rst), .link_ready(u_link), .align_done(u_align),
    .s_valid(u_valid), .s_ready(u_ready), .s_data(u_data), .s_ctl(u_ctl),
    .lane_ready(u_lrdy), .m_pop(u_pop), .m_word(u_word), .m_avail(u_avail));

  task automatic chk(input bit ok, input string tag, input logic [65:0] act, input logic [65:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pay(input int k, input int i);
    return {16'(k) + 16'h0100, 16'(i), 32'(k) * 32'h9E37};
  endfunction

  logic [65:0] q0[$];
  logic [65:0] q1[$];

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    chk(m_avail == 2'b00, "R1 empty", 66'(m_avail), 0);
    chk(!s_ready, "R1 s_ready", 66'(s_ready), 0);
    chk(lane_ready == 2'b11, "R1 lane_ready", 66'(lane_ready), 3);

    // R2: no link, source offering
    s_valid = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); #1;
      chk(m_avail == 2'b00 && !s_ready, "R2 idle", {m_avail, s_ready}, 0);
    end
    s_valid = 0;

    // R3/R6/R10: long filler phase up to full
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); link_ready = 1; #1;
      begin
        int c;
        c = (k < 16) ? k : 16;
        chk(!s_ready, "R3 no user in fill", 66'(s_ready), 0);
        chk(lane_ready == ((c < 8) ? 2'b11 : 2'b00), "R6 threshold", 66'(lane_ready), (c < 8) ? 3 : 0);
      end
    end
    @(negedge clk); link_ready = 0;
    for (int j = 0; j < 16; j++) begin
      m_pop = 2'b11; #1;
      chk(m_avail == 2'b11, "R10 fill count", 66'(m_avail), 3);
      chk(m_word[65:0] == FILLW && m_word[131:66] == FILLW, "R3 filler word", m_word[65:0], FILLW);
      @(negedge clk);
    end
    m_pop = 2'b00; #1;
    chk(m_avail == 2'b00, "R10 capped at depth", 66'(m_avail), 0);

    // reset again
    rst = 1; repeat (2) @(negedge clk); rst = 0;

    // R3/R4: short filler phase ending on alignment
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); link_ready = 1; align_done = (k == 3); #1;
      chk(!s_ready, "R4 filler through align cycle", 66'(s_ready), 0);
    end
    @(negedge clk); #1;
    chk(s_ready, "R4 user next cycle", 66'(s_ready), 1);
    for (int j = 0; j < 4; j++) begin
      m_pop = 2'b11; #1;
      chk(m_avail == 2'b11 && m_word[65:0] == FILLW && m_word[131:66] == FILLW,
          "R3 filler from first cycle", m_word[131:66], FILLW);
      @(negedge clk);
    end
    m_pop = 2'b00; #1;
    chk(m_avail == 2'b00, "R4 four fillers", 66'(m_avail), 0);

    // R7/R8/R9/R6: user stream with stalls
    begin
      int sent, got;
      sent = 0; got = 0;
      for (int cyc = 0; cyc < 600 && got < NBEAT; cyc++) begin
        @(negedge clk);
        link_ready = !(cyc >= 60 && cyc < 63);
        s_valid = (sent < NBEAT) && (cyc % 5 != 4);
        s_data = {pay(sent, 1), pay(sent, 0)};
        s_ctl = {1'(sent[0] ^ 1'b1), 1'(sent[0])};
        m_pop = (cyc >= 30 && cyc < 55) || (cyc % 3 == 0) ? 2'b00 : m_avail;
        #1;
        begin
          logic [1:0] er;
          logic es;
          er = {1'(q1.size() < 8), 1'(q0.size() < 8)};
          es = link_ready && (|er) && q0.size() < 16 && q1.size() < 16;
          chk(lane_ready == er, "R6 lane_ready", 66'(lane_ready), 66'(er));
          chk(s_ready == es, "R7 s_ready", 66'(s_ready), 66'(es));
          chk(m_avail == {1'(q1.size() != 0), 1'(q0.size() != 0)}, "R9 avail", 66'(m_avail), 66'(q0.size()));
          if (m_pop[0] && q0.size() != 0) begin
            chk(m_word[65:0] == q0[0], "R8 lane0 order", m_word[65:0], q0[0]);
            void'(q0.pop_front());
            got++;
          end
          if (m_pop[1] && q1.size() != 0) begin
            chk(m_word[131:66] == q1[0], "R8 lane1 order", m_word[131:66], q1[0]);
            void'(q1.pop_front());
          end
          if (s_valid && s_ready) begin
            q0.push_back({1'b1, s_ctl[0], s_data[63:0]});
            q1.push_back({1'b1, s_ctl[1], s_data[127:64]});
            sent++;
          end
        end
      end
      chk(got == NBEAT && sent == NBEAT, "R8 all delivered", 66'(got), NBEAT);
      @(negedge clk); m_pop = 0; s_valid = 0; #1;
      chk(m_avail == 2'b00, "R8 no duplicates", 66'(m_avail), 0);
    end

    // R5/R6 single lane: no filler, ready as link rises
    for (int j = 0; j < 3; j++) begin
      @(negedge clk); u_link = 1; u_valid = 1; u_data = pay(j, 7); u_ctl = 1'(j); #1;
      chk(u_ready == (j < 2), "R5 single-lane ready", 66'(u_ready), 66'(j < 2));
      chk(u_lrdy == (j < 2), "R6 single-lane threshold", 66'(u_lrdy), 66'(j < 2));
    end
    @(negedge clk); u_valid = 0;
    for (int j = 0; j < 2; j++) begin
      u_pop = 1; #1;
      chk(u_avail && u_word == {1'b1, 1'(j), pay(j, 7)}, "R5 user word not filler", u_word, {1'b1, 1'(j), pay(j, 7)});
      @(negedge clk);
    end
    u_pop = 0; #1;
    chk(!u_avail, "R9 single-lane drained", 66'(u_avail), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule